// File: doc/BRIEF.md
# Banked GPIO Interrupt Router

The router gathers the pending-interrupt flags of the pins in a bank of GPIO ports. A bank has up to eight ports, each with up to eight pins, and the router spreads those flags over a small set of interrupt output lines. Every pending flag is captured into a per-port status register. Software reads that register to find out which pins fired.

For every port and every output line there is a route mask. A set bit n connects pin n of that port to that line. One pin can therefore raise several lines at once, which lets interrupt handling be split across processors. Out of reset every implemented pin of every port is routed to line 0.

A security control register can seal the routing. It has a write lock and a read lock. Both are sticky: once set, each stays set until reset. While either lock is set the route masks cannot be changed. While the read lock is set the route masks read back as zero, but the routing they hold stays in force. Register access uses a simple strobed write port and a combinational read port.

Top module: `irq_bank_router`

## Requirements
- R1: After reset, the route mask for line 0 of each port equals that port's implemented-pin mask ((1 << pins) - 1). All other route masks, the security control register and every interrupt line read as zero.
- R2: The status register of port p is read at byte address 0x200 + 4*p. Its bit n holds the pending input of pin n as captured at the previous clock edge. Bits at or above the port's implemented pin count read as zero.
- R3: Interrupt line x is the OR over all ports of (status AND route mask for port p, line x). It therefore follows a pending input change one clock later.
- R4: The route mask for port p, line x is at byte address 0x14 + p*0x20 + x*4, and bit n selects pin n. A write stores the data ANDed with the port's implemented-pin mask, and a read returns the stored mask.
- R5: A single pin routed in the masks of several lines drives all of those lines high at the same time.
- R6: The security control register is at byte address 0x0C. Bit 28 is the write lock and bit 27 is the read lock. Writing a 1 sets a bit, and writing a 0 never clears it; only reset clears it. A read returns the two lock bits in those positions and zero everywhere else.
- R7: While either lock bit is set, writes to route masks are ignored.
- R8: While the read lock is set, route mask reads return zero, and the interrupt lines still follow the stored masks.
- R9: Addresses that are not mapped (including misaligned ones) read as zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pend_in | input | NPORTS*PIN_W | Pending flags; port p occupies bits [p*PIN_W +: PIN_W] |
| reg_wr_en | input | 1 | Write strobe, one cycle per write |
| reg_addr | input | ADDR_W | Byte address for reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| irq_out | output | NLINES | Interrupt output lines |

## Verification
The routing function is exercised with random route masks and random pending vectors. These random vectors also set pin bits above each port's pin count, which separates correct masking from a plain AND of pending and route. A directed case routes one pin to several lines, which exposes any one-hot line selection. Further directed cases apply each lock alone and then both together, and check the interrupt lines as well as the read data. This distinguishes a blocked write from a hidden read and shows that the lock bits survive an attempted clear.

// File: rtl/gir_pkg.sv
`timescale 1ns/1ps
// Package: address map and bit positions shared by the interrupt router.
// Assumes byte addressing with 32-bit registers on 4-byte boundaries.
package gir_pkg;
    localparam logic [31:0] SEC_OFS      = 32'h0000_000C;
    localparam logic [31:0] ROUTE_BASE   = 32'h0000_0014;
    localparam logic [31:0] PORT_STRIDE  = 32'h0000_0020;
    localparam logic [31:0] STATUS_BASE  = 32'h0000_0200;
    localparam int          WLOCK_BIT    = 28;
    localparam int          RLOCK_BIT    = 27;
endpackage

// File: rtl/gir_lock_ctrl.sv
`timescale 1ns/1ps
// Module: sticky security locks for the routing registers.
// Assumes wr_en is already decoded for the security register address.
// Lock bits can only be set by software; reset is the only way to clear.
module gir_lock_ctrl (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    output logic        wlock,
    output logic        rlock
);
    import gir_pkg::*;

    // Set-only update of the two lock bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wlock <= 1'b0;
            rlock <= 1'b0;
        end else if (wr_en) begin
            wlock <= wlock | wr_data[WLOCK_BIT];
            rlock <= rlock | wr_data[RLOCK_BIT];
        end
    end

    // R6
    wlock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wlock |=> wlock);
    // R6
    rlock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rlock |=> rlock);
endmodule

// File: rtl/gir_route_store.sv
`timescale 1ns/1ps
// Module: storage for the per-port, per-line route masks.
// Assumes impl_all is constant. Writes are masked to the implemented pins
// and are dropped while locked is high.
module gir_route_store #(
    parameter int NPORTS  = 4,
    parameter int NLINES  = 8,
    parameter int PIN_W   = 8,
    parameter int PORT_IW = 2,
    parameter int LINE_IW = 3
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NPORTS*PIN_W-1:0]        impl_all,
    input  logic                           wr_en,
    input  logic [PORT_IW-1:0]             wr_port,
    input  logic [LINE_IW-1:0]             wr_line,
    input  logic [PIN_W-1:0]               wr_data,
    input  logic                           locked,
    output logic [NPORTS*NLINES*PIN_W-1:0] route_flat
);
    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        for (genvar x = 0; x < NLINES; x++) begin : g_line
            localparam int BASE = (p * NLINES + x) * PIN_W;
            // Hold one route mask; the default sends every implemented pin to line 0.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    route_flat[BASE +: PIN_W] <= (x == 0) ? impl_all[p*PIN_W +: PIN_W]
                                                          : '0;
                end else if (wr_en && !locked && wr_port == PORT_IW'(p)
                             && wr_line == LINE_IW'(x)) begin
                    route_flat[BASE +: PIN_W] <= wr_data & impl_all[p*PIN_W +: PIN_W];
                end
            end
        end
    end

    // R7
    locked_route_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> $stable(route_flat));
endmodule

// File: rtl/gir_status_cap.sv
`timescale 1ns/1ps
// Module: captures pending flags into the per-port status registers.
// Assumes pend_in is synchronous to clk. Bits above each port's pin
// count are dropped.
module gir_status_cap #(
    parameter int NPORTS = 4,
    parameter int PIN_W  = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NPORTS*PIN_W-1:0] pend_in,
    input  logic [NPORTS*PIN_W-1:0] impl_all,
    output logic [NPORTS*PIN_W-1:0] status_flat
);
    // Sample pending flags once per clock, keeping only implemented pins.
    always_ff @(posedge clk) begin
        if (!rst_n) status_flat <= '0;
        else        status_flat <= pend_in & impl_all;
    end
endmodule

// File: rtl/gir_line_merge.sv
`timescale 1ns/1ps
// Module: combines status and route masks into the interrupt lines.
// Assumes both inputs come from registers. The output is combinational.
module gir_line_merge #(
    parameter int NPORTS = 4,
    parameter int NLINES = 8,
    parameter int PIN_W  = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NPORTS*PIN_W-1:0]        status_flat,
    input  logic [NPORTS*NLINES*PIN_W-1:0] route_flat,
    output logic [NLINES-1:0]              irq
);
    for (genvar x = 0; x < NLINES; x++) begin : g_line
        // OR together the routed pending pins of every port for this line.
        always_comb begin : merge
            logic hit;
            hit = 1'b0;
            for (int p = 0; p < NPORTS; p++) begin
                hit = hit | (|(status_flat[p*PIN_W +: PIN_W]
                               & route_flat[(p*NLINES + x)*PIN_W +: PIN_W]));
            end
            irq[x] = hit;
        end
    end

    // R3
    idle_lines_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status_flat == '0) |-> (irq == '0));
endmodule

// File: rtl/irq_bank_router.sv
`timescale 1ns/1ps
// Module: top of the banked GPIO interrupt router.
// Decodes the register address map, holds the lock, route and status
// registers, and drives the interrupt lines. Reads are combinational.
// Assumes NLINES <= 8 and PIN_W <= 8, as the address stride requires.
module irq_bank_router #(
    parameter int                    NPORTS    = 4,
    parameter int                    NLINES    = 8,
    parameter int                    PIN_W     = 8,
    parameter int                    ADDR_W    = 12,
    parameter logic [NPORTS*4-1:0]   PORT_PINS = 16'h8637
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NPORTS*PIN_W-1:0] pend_in,
    input  logic                    reg_wr_en,
    input  logic [ADDR_W-1:0]       reg_addr,
    input  logic [31:0]             reg_wdata,
    output logic [31:0]             reg_rdata,
    output logic [NLINES-1:0]       irq_out
);
    import gir_pkg::*;

    localparam int PORT_IW = (NPORTS > 1) ? $clog2(NPORTS) : 1;
    localparam int LINE_IW = (NLINES > 1) ? $clog2(NLINES) : 1;

    logic [NPORTS*PIN_W-1:0]        impl_all;
    logic [NPORTS*PIN_W-1:0]        status_flat;
    logic [NPORTS*NLINES*PIN_W-1:0] route_flat;
    logic                           wlock, rlock;
    logic [31:0]                    addr32, route_off, stat_off;
    logic                           sec_hit, route_hit, stat_hit;
    logic [PORT_IW-1:0]             r_port, s_port;
    logic [LINE_IW-1:0]             r_line;

    for (genvar p = 0; p < NPORTS; p++) begin : g_impl
        localparam int NPIN = int'(PORT_PINS[p*4 +: 4]);
        for (genvar n = 0; n < PIN_W; n++) begin : g_bit
            assign impl_all[p*PIN_W + n] = (n < NPIN);
        end
    end

    // Address decode for the security, route and status windows.
    always_comb begin
        addr32    = 32'(reg_addr);
        route_off = addr32 - ROUTE_BASE;
        stat_off  = addr32 - STATUS_BASE;
        sec_hit   = (addr32 == SEC_OFS);
        route_hit = (addr32 >= ROUTE_BASE) && (route_off < 32'(NPORTS) * PORT_STRIDE)
                    && (route_off[1:0] == 2'b00)
                    && ({29'd0, route_off[4:2]} < 32'(NLINES));
        stat_hit  = (addr32 >= STATUS_BASE) && (stat_off < 32'(NPORTS * 4))
                    && (stat_off[1:0] == 2'b00);
        r_port    = route_off[5 +: PORT_IW];
        r_line    = route_off[2 +: LINE_IW];
        s_port    = stat_off[2 +: PORT_IW];
    end

    gir_lock_ctrl u_lock (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr_en && sec_hit),
        .wr_data (reg_wdata),
        .wlock   (wlock),
        .rlock   (rlock)
    );

    gir_route_store #(
        .NPORTS(NPORTS), .NLINES(NLINES), .PIN_W(PIN_W),
        .PORT_IW(PORT_IW), .LINE_IW(LINE_IW)
    ) u_route (
        .clk        (clk),
        .rst_n      (rst_n),
        .impl_all   (impl_all),
        .wr_en      (reg_wr_en && route_hit),
        .wr_port    (r_port),
        .wr_line    (r_line),
        .wr_data    (reg_wdata[PIN_W-1:0]),
        .locked     (wlock | rlock),
        .route_flat (route_flat)
    );

    gir_status_cap #(.NPORTS(NPORTS), .PIN_W(PIN_W)) u_status (
        .clk         (clk),
        .rst_n       (rst_n),
        .pend_in     (pend_in),
        .impl_all    (impl_all),
        .status_flat (status_flat)
    );

    gir_line_merge #(.NPORTS(NPORTS), .NLINES(NLINES), .PIN_W(PIN_W)) u_merge (
        .clk         (clk),
        .rst_n       (rst_n),
        .status_flat (status_flat),
        .route_flat  (route_flat),
        .irq         (irq_out)
    );

    // Read multiplexer; hidden or unmapped registers return zero.
    always_comb begin
        reg_rdata = '0;
        if (sec_hit) begin
            reg_rdata[WLOCK_BIT] = wlock;
            reg_rdata[RLOCK_BIT] = rlock;
        end else if (route_hit && !rlock) begin
            reg_rdata[PIN_W-1:0] =
                route_flat[(int'(r_port)*NLINES + int'(r_line))*PIN_W +: PIN_W];
        end else if (stat_hit) begin
            reg_rdata[PIN_W-1:0] = status_flat[int'(s_port)*PIN_W +: PIN_W];
        end
    end

    // R8
    hidden_route_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rlock && route_hit) |-> (reg_rdata == 32'd0));
endmodule

// File: tb/irq_bank_router_tb.sv
`timescale 1ns/1ps
module irq_bank_router_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 4;
    localparam int NL = 8;
    localparam int PW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP*PW-1:0] pend_in = '0;
    logic          reg_wr_en = 1'b0;
    logic [11:0]   reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic [NL-1:0] irq_out;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic [7:0] m_route [NP][NL];
    logic [7:0] m_impl  [NP];

    irq_bank_router u_dut (
        .clk(clk), .rst_n(rst_n), .pend_in(pend_in), .reg_wr_en(reg_wr_en),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_out(irq_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    function automatic logic [11:0] route_addr(int p, int x);
        return 12'(32'h14 + p * 32'h20 + x * 4);
    endfunction

    function automatic logic [NL-1:0] exp_irq(logic [NP*PW-1:0] pend);
        logic [NL-1:0] r = '0;
        for (int x = 0; x < NL; x++)
            for (int p = 0; p < NP; p++)
                if ((pend[p*PW +: PW] & m_impl[p] & m_route[p][x]) != 0) r[x] = 1'b1;
        return r;
    endfunction

    task automatic model_reset();
        m_impl[0] = 8'h7F; m_impl[1] = 8'h07; m_impl[2] = 8'h3F; m_impl[3] = 8'hFF;
        for (int p = 0; p < NP; p++)
            for (int x = 0; x < NL; x++)
                m_route[p][x] = (x == 0) ? m_impl[p] : 8'h00;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; pend_in = '0; reg_wr_en = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr_en = 1'b1;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic drive_pend_check(input logic [NP*PW-1:0] v, input string req);
        logic [NL-1:0] e;
        @(negedge clk);
        pend_in = v;
        @(posedge clk);
        @(negedge clk);
        e = exp_irq(v);
        check(irq_out == e, req, 32'(irq_out), 32'(e));
    endtask

    task automatic check_defaults(input string req);
        logic [31:0] d;
        for (int p = 0; p < NP; p++)
            for (int x = 0; x < NL; x++) begin
                bus_read(route_addr(p, x), d);
                check(d == 32'(m_route[p][x]), req, d, 32'(m_route[p][x]));
            end
        bus_read(12'h00C, d);
        check(d == 32'd0, req, d, 32'd0);
        check(irq_out == '0, req, 32'(irq_out), 32'd0);
    endtask

    initial begin
        logic [31:0] d;
        logic [11:0] unm [7];
        unm = '{12'h000, 12'h008, 12'h010, 12'h0A0, 12'h100, 12'h210, 12'h016};
        void'($urandom(32'd20240611));

        do_reset();
        // R1: reset state
        check_defaults("R1");

        // R3: default routing sends all implemented pins to line 0
        drive_pend_check(32'h0000_0100, "R3");
        drive_pend_check(32'hFFFF_FFFF, "R3");
        // R2: status masks pins above the pin count (port1 has 3 pins)
        drive_pend_check(32'h0000_F800, "R2");
        bus_read(12'h204, d);
        check(d == 32'd0, "R2", d, 32'd0);

        // random mix of route programming, pending vectors and readback
        for (int it = 0; it < 60; it++) begin
            int p = int'($urandom_range(0, NP-1));
            int x = int'($urandom_range(0, NL-1));
            logic [31:0] w = $urandom;
            logic [NP*PW-1:0] v;
            int sp = int'($urandom_range(0, NP-1));
            bus_write(route_addr(p, x), w);
            m_route[p][x] = w[7:0] & m_impl[p];
            // R4: readback of the masked write
            bus_read(route_addr(p, x), d);
            check(d == 32'(m_route[p][x]), "R4", d, 32'(m_route[p][x]));
            v = $urandom;
            if (it % 4 == 0) v = '0;
            // R3: lines follow status AND route
            drive_pend_check(v, "R3");
            // R2: status register of a random port
            bus_read(12'(32'h200 + sp * 4), d);
            check(d == 32'(v[sp*PW +: PW] & m_impl[sp]), "R2", d,
                  32'(v[sp*PW +: PW] & m_impl[sp]));
            if (it % 6 == 0) begin
                int k = int'($urandom_range(0, 6));
                // R9: unmapped write changes nothing and reads zero
                bus_write(unm[k], 32'hFFFF_FFFF);
                bus_read(unm[k], d);
                check(d == 32'd0, "R9", d, 32'd0);
                bus_read(12'h00C, d);
                check(d == 32'd0, "R9", d, 32'd0);
                drive_pend_check(32'hFFFF_FFFF, "R9");
            end
        end

        // R5: one pin (port2 pin1) routed to lines 0,1,3,7
        for (int x = 0; x < NL; x++) begin
            for (int p = 0; p < NP; p++) begin
                m_route[p][x] = 8'h00;
                bus_write(route_addr(p, x), 32'd0);
            end
        end
        for (int x = 0; x < NL; x++) if (x == 0 || x == 1 || x == 3 || x == 7) begin
            m_route[2][x] = 8'h02;
            bus_write(route_addr(2, x), 32'h02);
        end
        drive_pend_check(32'h0002_0000, "R5");
        check(irq_out == 8'h8B, "R5", 32'(irq_out), 32'h8B);

        // R6: read lock alone
        bus_write(12'h00C, 32'h0800_0000);
        bus_read(12'h00C, d);
        check(d == 32'h0800_0000, "R6", d, 32'h0800_0000);
        // R7: write under read lock is ignored (observed on the lines)
        bus_write(route_addr(0, 5), 32'hFF);
        drive_pend_check(32'h0000_00FF, "R7");
        check(irq_out[5] == 1'b0, "R7", 32'(irq_out), 32'(exp_irq(32'hFF)));
        // R8: reads hidden, routing still active
        bus_read(route_addr(2, 1), d);
        check(d == 32'd0, "R8", d, 32'd0);
        drive_pend_check(32'h0002_0000, "R8");
        // R6: add write lock, then attempt to clear both
        bus_write(12'h00C, 32'h1000_0000);
        bus_read(12'h00C, d);
        check(d == 32'h1800_0000, "R6", d, 32'h1800_0000);
        bus_write(12'h00C, 32'h0000_0000);
        bus_read(12'h00C, d);
        check(d == 32'h1800_0000, "R6", d, 32'h1800_0000);
        // R7: write under both locks ignored
        bus_write(route_addr(3, 6), 32'hFF);
        drive_pend_check(32'hFF00_0000, "R7");

        // R6: reset clears locks; R1 defaults restored
        do_reset();
        check_defaults("R1");
        // R6: write lock alone blocks writes but reads stay visible
        bus_write(12'h00C, 32'h1000_0000);
        bus_write(route_addr(1, 2), 32'h07);
        bus_read(route_addr(1, 2), d);
        check(d == 32'd0, "R7", d, 32'd0);
        bus_read(route_addr(1, 0), d);
        check(d == 32'h07, "R6", d, 32'h07);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=0x%08h expected=0x%08h", 32'd0, 32'd1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule